// File: doc/BRIEF.md
# Limit-Compare Periodic Counter Timer

This block is a word-addressed 32-bit counter/timer. A prescaler turns the system clock into one tick every 500 ns. Each tick advances a 22-bit count that sits in bits 30:9 of the counter register, so one tick adds 0x200 to the value read back. The count is compared against a programmable limit. On the tick where the count would reach the limit, the count returns to zero. The same tick sets a sticky reached flag, which is bit 31 of the counter read value, and raises a level interrupt.

A limit of zero selects free-running operation. The count then rises to 0x7FFFFE00 and wraps, and it never matches.

Software uses a simple read/write port with a 2-bit word offset. The interrupt is acknowledged by reading the limit register, which also clears the reached flag. Two write offsets load the limit. One restarts the count and the prescaler. The other keeps the count running.

Top module: `tlt_timer`

## Requirements
- R1: The tick arrives once every TICK_NS of the CLK_HZ clock: one tick every CLK_HZ*TICK_NS/1e9 cycles. Each tick adds 0x200 to the counter read value. Bits 8:0 of the counter and limit values always read zero.
- R2: After reset, the limit, count, reached flag, interrupt and read data are all zero, and the counter runs in free-run mode.
- R3: With a nonzero limit L (in units of 0x200), the tick that would take the count to L sets the count to 0, sets the reached flag and raises `irq_o`. This repeats every L ticks.
- R4: A read at offset 1 returns `{reached, count[21:0], 9'b0}`. It has no side effect.
- R5: A read at offset 0 returns the limit and clears both the reached flag and `irq_o`.
- R6: A write at offset 0 loads the limit as `wdata & 0x7FFFFE00`. It restarts the count and the prescaler from zero and deasserts `irq_o`, which wins over a match in the same cycle.
- R7: A write at offset 2 loads the masked limit and leaves the count and the prescaler running. The compare is an equality, so a limit at or below the current count matches only after the count wraps.
- R8: A zero limit makes the count run up to 0x7FFFFE00 and then wrap to 0. The reached flag is never set by this and no interrupt is raised.
- R9: When a match occurs on the same clock edge as a read at offset 0, the match wins: the reached flag and `irq_o` are high after that edge.
- R10: Writes at offsets 1 and 3 change nothing. A read at offset 3 returns 0. A read at offset 2 returns the limit and clears nothing.
- R11: Read data is registered. `rsp_rdata` shows the state from before the access edge and appears one clock after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Word offset: 0 limit, 1 counter, 2 limit-keep-count, 3 status |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt on limit match |

## Verification
The compare is tried with a short limit of three ticks, which shows that the period equals the limit and that the reached flag is sticky across counter reads. A limit changed in mid-count through the keep-count offset separates a load that restarts the count from one that keeps it. A two-tick limit is arranged so that its match falls on the same edge as a limit read, which shows whether the match or the acknowledge wins. A zero limit and an unreachable all-ones limit are used alongside writes to the read-only offsets. Together these show free-run counting, limit masking, the tick rate and that the ignored writes leave every register unchanged.

// File: rtl/tlt_pkg.sv
package tlt_pkg;

    localparam int DATA_W  = 32;
    localparam int CNT_LSB = 9;
    localparam int CNT_MSB = 30;
    localparam int CNT_W   = CNT_MSB - CNT_LSB + 1;
    localparam int FLAG_BIT = 31;
    localparam int OFS_W   = 2;

    typedef enum logic [OFS_W-1:0] {
        OFS_LIMIT      = 2'd0,
        OFS_COUNT      = 2'd1,
        OFS_LIMIT_KEEP = 2'd2,
        OFS_STATUS     = 2'd3
    } reg_ofs_e;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] limit;
        logic             reached;
        logic             irq;
    } core_st_t;

endpackage

// File: rtl/tlt_tick_gen.sv
module tlt_tick_gen #(
    parameter int CLK_HZ  = 100_000_000,
    parameter int TICK_NS = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int DIV_RAW = ((CLK_HZ / 1000) * TICK_NS) / 1_000_000;
    localparam int DIV     = (DIV_RAW < 1) ? 1 : DIV_RAW;
    localparam int PW      = (DIV < 2) ? 1 : $clog2(DIV);

    typedef struct packed {
        logic [PW-1:0] phase;
    } pre_st_t;

    pre_st_t st_d, st_q;

    assign tick = (st_q.phase == PW'(DIV - 1));

    always_comb begin
        st_d = st_q;
        if (restart || tick) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        if (DIV > 1) begin : g_gap_chk
            // R1: ticks are never back to back when the divider exceeds one
            a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/tlt_core.sv
module tlt_core
    import tlt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ld_restart,
    input  logic             ld_keep,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             rd_ack,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] limit,
    output logic             reached,
    output logic             irq
);
    core_st_t st_d, st_q;
    logic     hit;

    assign hit = tick && (st_q.limit != '0) &&
                 ((st_q.count + 1'b1) == st_q.limit) && !ld_restart;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.count = hit ? '0 : st_q.count + 1'b1;
        end
        if (rd_ack) begin
            st_d.reached = 1'b0;
            st_d.irq     = 1'b0;
        end
        if (ld_keep) begin
            st_d.limit = ld_val;
        end
        if (ld_restart) begin
            st_d.limit = ld_val;
            st_d.count = '0;
            st_d.irq   = 1'b0;
        end
        if (hit) begin
            st_d.reached = 1'b1;
            st_d.irq     = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count   = st_q.count;
    assign limit   = st_q.limit;
    assign reached = st_q.reached;
    assign irq     = st_q.irq;

    a_r1_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_restart && !tick) |=> $stable(st_q.count));

    a_r3_match_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.limit != '0 && (st_q.count + 1'b1) == st_q.limit && !ld_restart)
        |=> (st_q.irq && st_q.reached && st_q.count == '0));

    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !tick) |=> (!st_q.irq && !st_q.reached));

    a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ld_restart |=> (st_q.count == '0 && !st_q.irq));

    a_r8_free_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.limit == '0 && !st_q.irq && !ld_keep && !ld_restart) |=> !st_q.irq);

    a_r8_free_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.limit == '0 && (&st_q.count) && !ld_restart) |=> st_q.count == '0);

    a_r9_match_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && hit) |=> (st_q.irq && st_q.reached));

endmodule

// File: rtl/tlt_regs.sv
module tlt_regs
    import tlt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [OFS_W-1:0]  req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  limit,
    input  logic              reached,
    output logic              ld_restart,
    output logic              ld_keep,
    output logic [CNT_W-1:0]  ld_val,
    output logic              rd_ack,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_st_t;

    rd_st_t   st_d, st_q;
    reg_ofs_e ofs;
    logic     is_wr, is_rd;
    logic [DATA_W-1:0] limit_word, count_word;
    logic     unused_wbits;

    assign ofs          = reg_ofs_e'(req_addr);
    assign is_wr        = req_valid && req_write;
    assign is_rd        = req_valid && !req_write;
    assign ld_val       = req_wdata[CNT_MSB:CNT_LSB];
    assign unused_wbits = ^{req_wdata[FLAG_BIT], req_wdata[CNT_LSB-1:0]};

    assign ld_restart = is_wr && (ofs == OFS_LIMIT);
    assign ld_keep    = is_wr && (ofs == OFS_LIMIT_KEEP);
    assign rd_ack     = is_rd && (ofs == OFS_LIMIT);

    always_comb begin
        limit_word = '0;
        limit_word[CNT_MSB:CNT_LSB] = limit;
        count_word = '0;
        count_word[CNT_MSB:CNT_LSB] = count;
        count_word[FLAG_BIT] = reached;
    end

    always_comb begin
        st_d = st_q;
        if (is_rd) begin
            unique case (ofs)
                OFS_LIMIT, OFS_LIMIT_KEEP: st_d.rdata = limit_word;
                OFS_COUNT:                 st_d.rdata = count_word;
                default:                   st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;

    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !is_rd |=> $stable(st_q.rdata));

    a_r1_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rdata[CNT_LSB-1:0] == '0);

endmodule

// File: rtl/tlt_timer.sv
module tlt_timer
    import tlt_pkg::*;
#(
    parameter int CLK_HZ  = 100_000_000,
    parameter int TICK_NS = 500
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [1:0]  req_addr,
    input  logic [31:0] req_wdata,
    output logic [31:0] rsp_rdata,
    output logic        irq_o
);
    logic             tick;
    logic             ld_restart, ld_keep, rd_ack;
    logic [CNT_W-1:0] ld_val, count, limit;
    logic             reached;

    tlt_tick_gen #(.CLK_HZ(CLK_HZ), .TICK_NS(TICK_NS)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ld_restart),
        .tick    (tick)
    );

    tlt_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .ld_restart (ld_restart),
        .ld_keep    (ld_keep),
        .ld_val     (ld_val),
        .rd_ack     (rd_ack),
        .count      (count),
        .limit      (limit),
        .reached    (reached),
        .irq        (irq_o)
    );

    tlt_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .count      (count),
        .limit      (limit),
        .reached    (reached),
        .ld_restart (ld_restart),
        .ld_keep    (ld_keep),
        .ld_val     (ld_val),
        .rd_ack     (rd_ack),
        .rdata      (rsp_rdata)
    );

    // R3: the interrupt can only rise on an edge where a tick was present
    a_r3_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(tick));

endmodule

// File: tb/tlt_timer_bench.sv
module tlt_timer_bench;
    // A 10 MHz nominal rate with 500 ns ticks gives a divide of 5 cycles per tick.
    localparam int DIV = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tlt_timer #(.CLK_HZ(10_000_000), .TICK_NS(500)) u_tlt_timer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] ofs, input logic [31:0] val);
        req_valid = 1'b1; req_write = 1'b1; req_addr = ofs; req_wdata = val;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
    endtask

    task automatic bus_read(input logic [1:0] ofs, output logic [31:0] val);
        req_valid = 1'b1; req_write = 1'b0; req_addr = ofs;
        @(negedge clk);
        req_valid = 1'b0;
        val = rsp_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R2 irq after reset", {31'b0, irq_o}, 32'h0);
        chk("R2 rdata after reset", rsp_rdata, 32'h0);
        bus_read(2'd1, v);
        chk("R2 count after reset", v, 32'h0);
        bus_read(2'd0, v);
        chk("R2 limit after reset", v, 32'h0);
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        bus_write(2'd0, 32'h0000_0600);            // edge E, limit 3 ticks
        idle(3*DIV - 1);                           // after E+14
        chk("R3 no irq before limit", {31'b0, irq_o}, 32'h0);
        idle(1);                                   // after E+15
        chk("R3 irq at limit", {31'b0, irq_o}, 32'h1);
        bus_read(2'd1, v);                         // edge E+16
        chk("R4 R11 count reload and reached flag", v, 32'h8000_0000);
        chk("R4 counter read keeps irq", {31'b0, irq_o}, 32'h1);
        bus_read(2'd0, v);                         // edge E+17
        chk("R5 limit read value", v, 32'h0000_0600);
        chk("R5 limit read clears irq", {31'b0, irq_o}, 32'h0);
        bus_read(2'd1, v);                         // edge E+18
        chk("R5 reached cleared", v, 32'h0);
        idle(11);                                  // after E+29
        chk("R3 second period not yet", {31'b0, irq_o}, 32'h0);
        idle(1);                                   // after E+30
        chk("R3 second period irq", {31'b0, irq_o}, 32'h1);
        idle(7);                                   // after E+37, count 1
        bus_write(2'd0, 32'h0000_0800);            // edge E+38
        chk("R6 write deasserts irq", {31'b0, irq_o}, 32'h0);
        bus_read(2'd1, v);                         // edge E+39
        chk("R6 write restarts count", v, 32'h8000_0000);
    endtask

    task automatic t_keep();
        logic [31:0] v;
        bus_write(2'd0, 32'h0000_1000);            // edge E, limit 8
        bus_read(2'd0, v);                         // edge E+1, clear flag
        idle(14);                                  // after E+15, count 3
        bus_write(2'd2, 32'h0000_0A00);            // edge E+16, limit 5
        idle(8);                                   // after E+24
        chk("R7 no irq before kept count reaches limit", {31'b0, irq_o}, 32'h0);
        idle(1);                                   // after E+25
        chk("R7 irq when kept count reaches new limit", {31'b0, irq_o}, 32'h1);
        bus_read(2'd2, v);                         // edge E+26
        chk("R10 offset 2 read returns limit", v, 32'h0000_0A00);
        chk("R10 offset 2 read keeps irq", {31'b0, irq_o}, 32'h1);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        bus_write(2'd0, 32'h0000_0400);            // edge E, limit 2
        idle(9);                                   // after E+9
        bus_read(2'd0, v);                         // edge E+10 = match
        chk("R9 limit read value on match edge", v, 32'h0000_0400);
        chk("R9 match wins over clearing read", {31'b0, irq_o}, 32'h1);
        bus_read(2'd1, v);                         // edge E+11
        chk("R9 reached kept on match edge", v, 32'h8000_0000);
    endtask

    task automatic t_freerun();
        logic [31:0] v;
        bus_write(2'd0, 32'h0);                    // edge E
        bus_read(2'd0, v);                         // edge E+1
        chk("R8 zero limit read", v, 32'h0);
        idle(99);                                  // after E+100
        chk("R8 no irq in free run", {31'b0, irq_o}, 32'h0);
        bus_read(2'd1, v);                         // edge E+101, 20 ticks
        chk("R8 R1 free run count", v, 32'h0000_2800);
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        bus_write(2'd0, 32'hFFFF_FFFF);            // edge E
        bus_write(2'd1, 32'hFFFF_FFFF);            // edge E+1
        bus_write(2'd3, 32'hFFFF_FFFF);            // edge E+2
        bus_read(2'd1, v);                         // edge E+3
        chk("R10 counter write ignored", v, 32'h0);
        idle(6);                                   // after E+9
        bus_read(2'd1, v);                         // edge E+10, 1 tick
        chk("R1 one tick step", v, 32'h0000_0200);
        bus_read(2'd1, v);                         // edge E+11, 2 ticks
        chk("R1 two tick step", v, 32'h0000_0400);
        bus_read(2'd3, v);
        chk("R10 status reads zero", v, 32'h0);
        bus_read(2'd0, v);
        chk("R6 limit masked", v, 32'h7FFF_FE00);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_periodic();
        t_keep();
        t_collision();
        t_freerun();
        t_ignored();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule